// File: doc/BRIEF.md
# I2C Target Engine with Status Flags

This block lets a chip answer as a target (slave) on an I2C bus. It samples the bus clock and data lines, spots START and STOP, compares the first byte after START against a programmed 7-bit address and, on a hit, drives the acknowledge bit. In a write transfer it shifts received bytes into a data port. In a read transfer it shifts bytes that software placed in the same data port out onto the bus, most significant bit first. Software drives it through five byte-wide registers. The block reports what happened through a set of sticky status flags, and it raises one interrupt line whenever an enabled flag is set.

Software clears a status flag by writing a 0 to that bit. Writing a 1 leaves the bit alone, so one flag can be cleared by writing the inverse of its mask. When a received byte or an empty transmit slot is waiting for software, the engine holds the clock line low after the acknowledge slot. It lets the line go once software clears the matching flag. A control bit can force the next received byte to be answered with NACK. A second control bit lets the engine answer the general-call address.

Register offsets are: 0 control, 1 own address (bits 6:0), 2 status, 3 interrupt enable, 4 data port. Writes to the data port load the transmit byte. Reads return the last received byte. Control bits are: 0 force-NACK, 1 general-call enable, 2 interface enable, 3 buffer select (stored only). Status and interrupt-enable bits are: 0 address hit, 1 byte received, 2 byte sent, 3 transmit slot empty, 4 STOP seen, 5 master reading, 6 general call seen.

Top module: `i2ct_target`

## Requirements
- R1: After reset the status, control and interrupt-enable registers read 0, the interrupt is low and neither bus line is driven.
- R2: A write-direction address byte whose upper 7 bits equal the own-address register is ACKed in the ninth clock, and it sets status bit 0 with bit 5 left clear.
- R3: Writing the status register clears every bit written as 0 and keeps every bit written as 1.
- R4: An address that does not match is not ACKed and sets no status bit, not even STOP (bit 4).
- R5: In a write transfer each data byte is ACKed and sets status bit 1, and the data port then returns it. The engine holds SCL low after the ACK slot until bit 1 is cleared.
- R6: With force-NACK (control bit 0) set, the next received byte gets NACK and sets status bit 1, and SCL is not held.
- R7: A read-direction address hit is ACKed and sets status bits 0, 5 and 3. SCL is held until bit 3 is cleared, and then the data-port byte goes out MSB first.
- R8: After each transmitted byte, status bit 2 is set. A master ACK also sets bit 3 again and holds SCL. A master NACK sets neither.
- R9: A STOP that ends a transfer in which this target was addressed sets status bit 4. A STOP on the bus returns the engine to idle.
- R10: Address 0 in the write direction is ACKed only when control bit 1 is set. It then sets status bits 6 and 0.
- R11: The interrupt output is high exactly while some status bit and its interrupt-enable bit are both 1.
- R12: With control bit 2 clear, the engine ignores the bus. It sends no ACK and sets no flag.
- R13: The engine's own SDA drive changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| irq | output | 1 | Interrupt request |

## Verification
The bench sends write transfers with matching, near-miss and high-bit-different addresses. A design that compared too few address bits would ACK a stranger, and one that kept the forced NACK off would ACK a byte it was told to refuse. The read path is checked across an ACKed byte followed by a NACKed one. A design that raised the empty flag after the final NACK would hang the bus on a held clock. A design that released the clock before software cleared a flag would lose bytes. The tests also cover general calls with the enable on and off, STOP flagging only after a hit, and the write-1-keeps rule on the status register, which a design that cleared on any write would break.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  localparam int BYTE_W = 8;
  localparam int NFLAG  = 7;

  // status / interrupt-enable bit positions
  localparam int F_ADR = 0;
  localparam int F_RXD = 1;
  localparam int F_TXD = 2;
  localparam int F_EMP = 3;
  localparam int F_STP = 4;
  localparam int F_TXM = 5;
  localparam int F_GC  = 6;

  // control bit positions
  localparam int C_FNACK = 0;
  localparam int C_GCE   = 1;
  localparam int C_EN    = 2;
  localparam int C_BSEL  = 3;
  localparam int CTRL_W  = 4;

  // register offsets
  localparam int A_CTRL = 0;
  localparam int A_OWN  = 1;
  localparam int A_STAT = 2;
  localparam int A_IEN  = 3;
  localparam int A_DATA = 4;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_RXBIT, S_RXACK, S_HOLDRX,
    S_TXLD, S_TXBIT, S_TXACK, S_HOLDTX, S_WAITP
  } eng_state_t;
endpackage

// File: rtl/i2ct_line_sync.sv
module i2ct_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic rst_n,
  output logic scl_q,
  output logic sda_q,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic [1:0]      rsync_q;
  logic [STAGES:0] scl_sh, sda_sh, scl_sh_n, sda_sh_n;
  logic            scl_p, sda_p;

  // reset: asserted at once, released on a clock edge
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rsync_q <= 2'b00;
    else         rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n = rsync_q[1];

  always_comb begin
    scl_sh_n = {scl_sh[STAGES-1:0], scl_i};
    sda_sh_n = {sda_sh[STAGES-1:0], sda_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= scl_sh_n;
      sda_sh <= sda_sh_n;
    end
  end

  assign scl_q = scl_sh[STAGES-1];
  assign sda_q = sda_sh[STAGES-1];
  assign scl_p = scl_sh[STAGES];
  assign sda_p = sda_sh[STAGES];

  assign start_o    = scl_q & scl_p & sda_p & ~sda_q;
  assign stop_o     = scl_q & scl_p & ~sda_p & sda_q;
  assign scl_rise_o = scl_q & ~scl_p;
  assign scl_fall_o = ~scl_q & scl_p;
endmodule

// File: rtl/i2ct_engine.sv
module i2ct_engine
  import i2ct_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_q,
  input  logic              sda_q,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              en_i,
  input  logic              gce_i,
  input  logic              fnack_i,
  input  logic [6:0]        own_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  input  logic              rxd_pend_i,
  input  logic              emp_pend_i,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic [NFLAG-1:0]  ev_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  eng_state_t        st_q, st_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [BYTE_W-1:0] sh_q, sh_n, rxb_q, rxb_n;
  logic              rw_q, rw_n, nak_q, nak_n, sel_q, sel_n;
  logic              own_hit, gc_hit;

  assign own_hit = (sh_q[BYTE_W-1:1] == own_i);
  assign gc_hit  = (sh_q[BYTE_W-1:1] == 7'd0) & ~sh_q[0] & gce_i;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    sh_n  = sh_q;
    rxb_n = rxb_q;
    rw_n  = rw_q;
    nak_n = nak_q;
    sel_n = sel_q;
    ev_o  = '0;
    if (stop_i) begin
      st_n  = S_IDLE;
      sel_n = 1'b0;
      if (sel_q) ev_o[F_STP] = 1'b1;
    end else if (start_i) begin
      st_n  = en_i ? S_ADDR : S_IDLE;
      cnt_n = '0;
      sel_n = 1'b0;
    end else begin
      unique case (st_q)
        S_ADDR, S_RXBIT: begin
          if (rise_i) begin
            sh_n  = {sh_q[BYTE_W-2:0], sda_q};
            cnt_n = cnt_q + 1'b1;
          end else if (fall_i && cnt_q == CNT_FULL) begin
            if (st_q == S_ADDR) begin
              rw_n = sh_q[0];
              if (own_hit || gc_hit) begin
                st_n         = S_AACK;
                sel_n        = 1'b1;
                ev_o[F_ADR]  = 1'b1;
                ev_o[F_GC]   = gc_hit;
                ev_o[F_TXM]  = sh_q[0];
              end else begin
                st_n = S_WAITP;
              end
            end else begin
              rxb_n       = sh_q;
              ev_o[F_RXD] = 1'b1;
              nak_n       = fnack_i;
              st_n        = S_RXACK;
            end
          end
        end
        S_AACK: begin
          if (fall_i) begin
            if (rw_q) begin
              st_n        = S_HOLDTX;
              ev_o[F_EMP] = 1'b1;
            end else begin
              st_n  = S_RXBIT;
              cnt_n = '0;
            end
          end
        end
        S_RXACK: begin
          if (fall_i) st_n = nak_q ? S_WAITP : S_HOLDRX;
        end
        S_HOLDRX: begin
          if (!rxd_pend_i) begin
            st_n  = S_RXBIT;
            cnt_n = '0;
          end
        end
        S_HOLDTX: begin
          if (!emp_pend_i) begin
            sh_n  = tx_byte_i;
            cnt_n = '0;
            st_n  = S_TXLD;
          end
        end
        S_TXLD: st_n = S_TXBIT;
        S_TXBIT: begin
          if (fall_i) begin
            sh_n  = {sh_q[BYTE_W-2:0], 1'b0};
            cnt_n = cnt_q + 1'b1;
            if (cnt_q == CNT_LAST) st_n = S_TXACK;
          end
        end
        S_TXACK: begin
          if (rise_i) begin
            nak_n       = sda_q;
            ev_o[F_TXD] = 1'b1;
          end else if (fall_i) begin
            if (!nak_q) begin
              st_n        = S_HOLDTX;
              ev_o[F_EMP] = 1'b1;
            end else begin
              st_n = S_WAITP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
      rxb_q <= '0;
      rw_q  <= 1'b0;
      nak_q <= 1'b0;
      sel_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      sh_q  <= sh_n;
      rxb_q <= rxb_n;
      rw_q  <= rw_n;
      nak_q <= nak_n;
      sel_q <= sel_n;
    end
  end

  assign sda_oe = (st_q == S_AACK) | ((st_q == S_RXACK) & ~nak_q) |
                  (((st_q == S_TXLD) | (st_q == S_TXBIT)) & ~sh_q[BYTE_W-1]);
  assign scl_oe = (st_q == S_HOLDRX) | (st_q == S_HOLDTX) | (st_q == S_TXLD);
  assign rx_byte_o = rxb_q;

  // R13: own SDA drive is steady while SCL stays high
  a_r13_sda_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_q && $past(scl_q)) |-> $stable(sda_oe));
  // R9: a STOP returns the engine to idle with SDA released
  a_r9_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (st_q == S_IDLE) && !sda_oe);
  // R5: receive hold lasts only while the byte is still pending
  a_r5_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == S_HOLDRX) && $past(st_q == S_HOLDRX)) |-> $past(rxd_pend_i));
endmodule

// File: rtl/i2ct_regs.sv
module i2ct_regs
  import i2ct_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic [NFLAG-1:0]  ev_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [6:0]        own_o,
  output logic [BYTE_W-1:0] tx_byte_o,
  output logic              rxd_pend_o,
  output logic              emp_pend_o,
  output logic              irq
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [6:0]        own_q;
  logic [NFLAG-1:0]  st_q, st_n, ien_q;
  logic [BYTE_W-1:0] txd_q;
  logic we_ctrl, we_own, we_stat, we_ien, we_data;

  assign we_ctrl = reg_we & (reg_addr == AW'(A_CTRL));
  assign we_own  = reg_we & (reg_addr == AW'(A_OWN));
  assign we_stat = reg_we & (reg_addr == AW'(A_STAT));
  assign we_ien  = reg_we & (reg_addr == AW'(A_IEN));
  assign we_data = reg_we & (reg_addr == AW'(A_DATA));

  // status: write-zero-to-clear, new events win over a clear
  always_comb begin
    st_n = st_q;
    if (we_stat) st_n = st_q & reg_wdata[NFLAG-1:0];
    st_n = st_n | ev_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      own_q  <= '0;
      st_q   <= '0;
      ien_q  <= '0;
      txd_q  <= '0;
    end else begin
      st_q <= st_n;
      if (we_ctrl) ctrl_q <= reg_wdata[CTRL_W-1:0];
      if (we_own)  own_q  <= reg_wdata[6:0];
      if (we_ien)  ien_q  <= reg_wdata[NFLAG-1:0];
      if (we_data) txd_q  <= reg_wdata;
    end
  end

  always_comb begin
    unique case (reg_addr)
      AW'(A_CTRL): reg_rdata = BYTE_W'(ctrl_q);
      AW'(A_OWN):  reg_rdata = BYTE_W'(own_q);
      AW'(A_STAT): reg_rdata = BYTE_W'(st_q);
      AW'(A_IEN):  reg_rdata = BYTE_W'(ien_q);
      AW'(A_DATA): reg_rdata = rx_byte_i;
      default:     reg_rdata = '0;
    endcase
  end

  assign ctrl_o     = ctrl_q;
  assign own_o      = own_q;
  assign tx_byte_o  = txd_q;
  assign rxd_pend_o = st_q[F_RXD];
  assign emp_pend_o = st_q[F_EMP];
  assign irq        = |(st_q & ien_q);

  // R3: a bit written as 0 with no event in that cycle reads 0 next
  for (genvar b = 0; b < NFLAG; b++) begin : g_clr
    a_r3_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (we_stat && !reg_wdata[b] && !ev_i[b]) |=> !st_q[b]);
  end
  // R3: an all-ones write keeps every flag
  a_r3_ones_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (we_stat && (&reg_wdata[NFLAG-1:0])) |=> st_q == ($past(st_q) | $past(ev_i)));
  // R2: every engine event lands in the status register
  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_i) |=> ((st_q & $past(ev_i)) == $past(ev_i)));
endmodule

// File: rtl/i2ct_target.sv
module i2ct_target
  import i2ct_pkg::*;
#(
  parameter int AW          = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              irq
);
  logic              rst_n, scl_q, sda_q, start, stop, rise, fall;
  logic [CTRL_W-1:0] ctrl;
  logic [6:0]        own;
  logic [BYTE_W-1:0] tx_byte, rx_byte;
  logic              rxd_pend, emp_pend;
  logic [NFLAG-1:0]  ev;

  i2ct_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .arst_n(arst_n), .scl_i(scl_i), .sda_i(sda_i),
    .rst_n(rst_n), .scl_q(scl_q), .sda_q(sda_q),
    .start_o(start), .stop_o(stop), .scl_rise_o(rise), .scl_fall_o(fall)
  );

  i2ct_engine u_eng (
    .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .sda_q(sda_q),
    .start_i(start), .stop_i(stop), .rise_i(rise), .fall_i(fall),
    .en_i(ctrl[C_EN]), .gce_i(ctrl[C_GCE]), .fnack_i(ctrl[C_FNACK]),
    .own_i(own), .tx_byte_i(tx_byte),
    .rxd_pend_i(rxd_pend), .emp_pend_i(emp_pend),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .rx_byte_o(rx_byte), .ev_o(ev)
  );

  i2ct_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_i(ev), .rx_byte_i(rx_byte),
    .ctrl_o(ctrl), .own_o(own), .tx_byte_o(tx_byte),
    .rxd_pend_o(rxd_pend), .emp_pend_o(emp_pend), .irq(irq)
  );
endmodule

// File: tb/i2ct_target_test.sv
module i2ct_target_test;
  import i2ct_pkg::*;
  localparam int HALF = 20;
  localparam logic [6:0] OWN = 7'h2C;

  logic clk, arst_n, scl_m, sda_m, scl_bus, sda_bus;
  logic reg_we;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic scl_oe, sda_oe, irq;
  int n_cmp, n_bad;

  assign scl_bus = scl_m & ~scl_oe;
  assign sda_bus = sda_m & ~sda_oe;

  i2ct_target uut (
    .clk(clk), .arst_n(arst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {force_nack, addr[6:0], data[7:0], exp_addr_ack, exp_data_ack}
  localparam logic [17:0] WV [0:4] = '{
    {1'b0, 7'h2C, 8'h96, 1'b1, 1'b1},
    {1'b0, 7'h2C, 8'h00, 1'b1, 1'b1},
    {1'b1, 7'h2C, 8'hFF, 1'b1, 1'b0},
    {1'b0, 7'h2D, 8'h55, 1'b0, 1'b0},
    {1'b0, 7'h6C, 8'h81, 1'b0, 1'b0}
  };

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input int a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input int a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = 3'(a);
    #1 d = reg_rdata;
  endtask

  task automatic bit_xfer(input logic b, output logic seen);
    sda_m = b;
    wait_cyc(HALF);
    scl_m = 1'b1;
    wait (scl_bus === 1'b1);
    wait_cyc(HALF / 2);
    seen = sda_bus;
    wait_cyc(HALF / 2);
    scl_m = 1'b0;
    wait_cyc(HALF);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_xfer(b[i], s);
    bit_xfer(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    logic s;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      bit_xfer(1'b1, s);
      b = {b[6:0], s};
    end
    bit_xfer(~mack, s);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1;
    wait (scl_bus === 1'b1);
    wait_cyc(HALF);
    sda_m = 1'b0;
    wait_cyc(HALF);
    scl_m = 1'b0;
    wait_cyc(HALF);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0;
    wait_cyc(HALF);
    scl_m = 1'b1;
    wait (scl_bus === 1'b1);
    wait_cyc(HALF);
    sda_m = 1'b1;
    wait_cyc(HALF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic ack;
    n_cmp = 0; n_bad = 0;
    arst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    wait_cyc(5);
    @(negedge clk) arst_n = 1'b1;
    wait_cyc(5);

    // R1 reset state
    reg_rd(A_STAT, d); chk("R1 status", d, 8'h00);
    reg_rd(A_CTRL, d); chk("R1 control", d, 8'h00);
    reg_rd(A_IEN, d);  chk("R1 ien", d, 8'h00);
    chk("R1 irq", irq, 1'b0);
    chk("R1 lines", {scl_oe, sda_oe}, 2'b00);

    reg_wr(A_OWN, {1'b0, OWN});

    // table of write transfers (R2 R4 R5 R6 R9)
    for (int v = 0; v < 5; v++) begin
      logic [17:0] e;
      e = WV[v];
      reg_wr(A_CTRL, 8'h04 | {7'd0, e[17]});
      reg_wr(A_STAT, 8'h00);
      bus_start();
      send_byte({e[16:10], 1'b0}, ack);
      chk(e[1] ? "R2 addr ack" : "R4 addr nack", ack, e[1]);
      reg_rd(A_STAT, d);
      chk(e[1] ? "R2 addr flags" : "R4 no flags", d, {7'd0, e[1]});
      if (e[1]) begin
        send_byte(e[9:2], ack);
        chk(e[0] ? "R5 data ack" : "R6 forced nack", ack, e[0]);
        reg_rd(A_STAT, d);  chk("R5 rx flag", d, 8'h03);
        reg_rd(A_DATA, d);  chk("R5 rx byte", d, e[9:2]);
        chk(e[0] ? "R5 scl held" : "R6 scl free", scl_oe, e[0]);
        reg_wr(A_STAT, 8'hFD);
        wait_cyc(4);
        chk("R5 scl released", scl_oe, 1'b0);
      end
      bus_stop();
      reg_rd(A_STAT, d);
      chk("R9 stop flag", d[4], e[1]);
    end

    // read transfer (R7 R8 R9)
    reg_wr(A_CTRL, 8'h04);
    reg_wr(A_STAT, 8'h00);
    bus_start();
    send_byte({OWN, 1'b1}, ack);
    chk("R7 read addr ack", ack, 1'b1);
    reg_rd(A_STAT, d); chk("R7 read flags", d, 8'h29);
    chk("R7 scl held", scl_oe, 1'b1);
    reg_wr(A_DATA, 8'hA5);
    reg_wr(A_STAT, 8'hF7);
    recv_byte(1'b1, d); chk("R7 byte out", d, 8'hA5);
    reg_rd(A_STAT, d); chk("R8 after ack", d, 8'h2D);
    chk("R8 scl held", scl_oe, 1'b1);
    reg_wr(A_DATA, 8'h3C);
    reg_wr(A_STAT, 8'hF3);
    recv_byte(1'b0, d); chk("R7 second byte", d, 8'h3C);
    reg_rd(A_STAT, d); chk("R8 after nack", d, 8'h25);
    chk("R8 scl free", scl_oe, 1'b0);
    bus_stop();
    reg_rd(A_STAT, d); chk("R9 stop after read", d, 8'h35);

    // R3 write-zero-to-clear
    reg_wr(A_STAT, 8'hFF); reg_rd(A_STAT, d); chk("R3 ones keep", d, 8'h35);
    reg_wr(A_STAT, 8'hDF); reg_rd(A_STAT, d); chk("R3 one cleared", d, 8'h15);
    reg_wr(A_STAT, 8'h00); reg_rd(A_STAT, d); chk("R3 all cleared", d, 8'h00);

    // R10 general call
    bus_start(); send_byte(8'h00, ack); bus_stop();
    chk("R10 gc refused", ack, 1'b0);
    reg_rd(A_STAT, d); chk("R10 gc no flags", d, 8'h00);
    reg_wr(A_CTRL, 8'h06);
    bus_start(); send_byte(8'h00, ack);
    chk("R10 gc ack", ack, 1'b1);
    reg_rd(A_STAT, d); chk("R10 gc flags", d, 8'h41);
    bus_stop();
    reg_rd(A_STAT, d); chk("R10 gc stop", d, 8'h51);

    // R11 interrupt
    reg_wr(A_IEN, 8'h01); chk("R11 irq on", irq, 1'b1);
    reg_wr(A_IEN, 8'h2E); chk("R11 irq masked", irq, 1'b0);
    reg_wr(A_IEN, 8'h10); chk("R11 irq stop", irq, 1'b1);
    reg_wr(A_STAT, 8'h00); chk("R11 irq cleared", irq, 1'b0);

    // R12 disabled interface
    reg_wr(A_CTRL, 8'h00);
    bus_start(); send_byte({OWN, 1'b0}, ack); bus_stop();
    chk("R12 no ack", ack, 1'b0);
    reg_rd(A_STAT, d); chk("R12 no flags", d, 8'h00);
    chk("R12 lines", {scl_oe, sda_oe}, 2'b00);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule